// File: doc/BRIEF.md
# Sixteen-Bit Invertible-Operand ALU

This block is a purely combinational 16-bit arithmetic and logic unit. One 3-bit operation code selects a rotate, one of three shifts, a two's-complement add, or a bitwise OR, XOR or AND. Before the selected operation, either operand can be complemented on its own. Together with an external carry into the least significant adder bit, this gives subtraction and other derived forms without extra opcodes.

The shift and rotate operations treat operand A (after any inversion) as the data. The low four bits of operand B (after any inversion) give the distance. The adder is a two-level carry-lookahead design built from 4-bit lookahead groups. A mode input decides whether the overflow flag reports signed two's-complement overflow or an unsigned carry out of the top bit. A zero flag reports an all-zero result for every operation.

Top module: `alu16_top`

## Requirements
- R1: Code 3'b000 rotates the effective A left by the effective B[3:0] positions. Bits leaving bit 15 re-enter at bit 0.
- R2: Code 3'b001 shifts the effective A left by the effective B[3:0] positions and fills the vacated low bits with zero.
- R3: Code 3'b010 shifts the effective A right by the effective B[3:0] positions and fills the vacated high bits with the effective A bit 15.
- R4: Code 3'b011 shifts the effective A right by the effective B[3:0] positions and fills the vacated high bits with zero.
- R5: Code 3'b100 gives the low 16 bits of effective A + effective B + carryIn. With invertB=1 and carryIn=1 this is A minus B.
- R6: Codes 3'b101, 3'b110 and 3'b111 give the bitwise OR, XOR and AND, in that order, of the effective operands.
- R7: invertA=1 replaces A by its bitwise complement before every operation, and invertB=1 does the same for B. The effective operands named in the other requirements are these values.
- R8: For code 3'b100 with signedMode=1, overflow is 1 exactly when the true signed sum of the effective operands and carryIn lies outside -32768..32767.
- R9: For code 3'b100 with signedMode=0, overflow is 1 exactly when the unsigned sum of the effective operands and carryIn exceeds 65535.
- R10: overflow is 0 for every code other than 3'b100.
- R11: isZero is 1 exactly when result is 16'h0000, for every code.
- R12: carryIn has no effect on result, overflow or isZero for any code other than 3'b100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand; the data for shift and rotate |
| opB | input | 16 | Second operand; bits 3:0 give the shift distance |
| carryIn | input | 1 | Carry into the least significant adder bit |
| opSel | input | 3 | Operation code |
| invertA | input | 1 | Complement A before the operation |
| invertB | input | 1 | Complement B before the operation |
| signedMode | input | 1 | 1 selects signed overflow, 0 selects unsigned carry |
| result | output | 16 | Operation result |
| overflow | output | 1 | Arithmetic overflow for the add code |
| isZero | output | 1 | Result equals zero |

## Verification
Operand inversion and the selected operation always act together. The bench therefore runs every opcode under all sixteen settings of invertA, invertB, carryIn and signedMode. This includes shifts whose distance comes from a complemented B. The overflow and zero flags can also rise together: all-ones plus one, and the most negative value added to itself, wrap to zero with a carry or signed overflow. These operand pairs are in the vector set. Each outcome is compared with a reference computed in wider integer arithmetic.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [2:0] {
    OP_ROL = 3'b000,
    OP_SHL = 3'b001,
    OP_SAR = 3'b010,
    OP_SHR = 3'b011,
    OP_ADD = 3'b100,
    OP_OR  = 3'b101,
    OP_XOR = 3'b110,
    OP_AND = 3'b111
  } aluOp_e;

  typedef enum logic [1:0] {
    SH_ROL = 2'b00,
    SH_SHL = 2'b01,
    SH_SAR = 2'b10,
    SH_SHR = 2'b11
  } shMode_e;

  typedef enum logic [1:0] {
    RES_SHIFT = 2'b00,
    RES_SUM   = 2'b01,
    RES_LOGIC = 2'b10
  } resSel_e;

  typedef enum logic [1:0] {
    LG_OR  = 2'b00,
    LG_XOR = 2'b01,
    LG_AND = 2'b10
  } lgOp_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    resSel_e resSel;
    shMode_e shMode;
    lgOp_e   lgOp;
    logic    ovfEn;
  } aluStrobes_t;

endpackage

// File: rtl/alu16_ctrl.sv
module alu16_ctrl
  import alu16_pkg::*;
(
  input  logic [2:0]  opSel,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes = '{resSel: RES_SHIFT, shMode: SH_ROL, lgOp: LG_OR, ovfEn: 1'b0};
    unique case (aluOp_e'(opSel))
      OP_ROL: strobes.shMode = SH_ROL;
      OP_SHL: strobes.shMode = SH_SHL;
      OP_SAR: strobes.shMode = SH_SAR;
      OP_SHR: strobes.shMode = SH_SHR;
      OP_ADD: begin
        strobes.resSel = RES_SUM;
        strobes.ovfEn  = 1'b1;
      end
      OP_OR: begin
        strobes.resSel = RES_LOGIC;
        strobes.lgOp   = LG_OR;
      end
      OP_XOR: begin
        strobes.resSel = RES_LOGIC;
        strobes.lgOp   = LG_XOR;
      end
      OP_AND: begin
        strobes.resSel = RES_LOGIC;
        strobes.lgOp   = LG_AND;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu16_shifter.sv
module alu16_shifter
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [AMT_W-1:0] amt,
  input  shMode_e          mode,
  output logic [WIDTH-1:0] dout
);

  logic goLeft, isRol, isSar;
  logic [AMT_W:0][WIDTH-1:0] stg;

  assign goLeft = (mode == SH_ROL) || (mode == SH_SHL);
  assign isRol  = (mode == SH_ROL);
  assign isSar  = (mode == SH_SAR);
  assign stg[0] = din;

  // One mux rank per distance bit; stage k moves by 2**k
  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int D = 1 << k;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic lft, rgt;
      if (i >= D) begin : g_lin
        assign lft = stg[k][i-D];
      end else begin : g_lwrap
        assign lft = isRol & stg[k][WIDTH-D+i];
      end
      if (i + D < WIDTH) begin : g_rin
        assign rgt = stg[k][i+D];
      end else begin : g_rfill
        assign rgt = isSar & stg[k][WIDTH-1];
      end
      assign stg[k+1][i] = amt[k] ? (goLeft ? lft : rgt) : stg[k][i];
    end
  end

  assign dout = stg[AMT_W];

endmodule

// File: rtl/alu16_cla_group.sv
module alu16_cla_group #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  input  logic          cin,
  output logic [GW-1:0] sum,
  output logic          grpGen,
  output logic          grpProp
);

  logic [GW-1:0] gen, prop;
  logic [GW:0]   carry;

  assign gen  = a & b;
  assign prop = a ^ b;

  // Each carry is expanded from the group inputs and cin
  always_comb begin
    for (int i = 0; i <= GW; i++) begin
      logic c;
      c = 1'b0;
      for (int j = 0; j < i; j++) begin
        logic term;
        term = gen[j];
        for (int m = j + 1; m < i; m++) term = term & prop[m];
        c = c | term;
      end
      begin
        logic pAll;
        pAll = 1'b1;
        for (int m = 0; m < i; m++) pAll = pAll & prop[m];
        c = c | (pAll & cin);
      end
      carry[i] = c;
    end
  end

  assign sum = prop ^ carry[GW-1:0];

  always_comb begin
    grpGen  = 1'b0;
    grpProp = 1'b1;
    for (int j = 0; j < GW; j++) begin
      grpGen  = gen[j] | (prop[j] & grpGen);
      grpProp = grpProp & prop[j];
    end
  end

endmodule

// File: rtl/alu16_adder.sv
module alu16_adder #(
  parameter int WIDTH = 16,
  parameter int GW    = 4,
  localparam int NG   = WIDTH / GW
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  logic [NG-1:0] gG, gP;
  logic [NG:0]   gC;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    alu16_cla_group #(.GW(GW)) i_grp (
      .a      (a[g*GW +: GW]),
      .b      (b[g*GW +: GW]),
      .cin    (gC[g]),
      .sum    (sum[g*GW +: GW]),
      .grpGen (gG[g]),
      .grpProp(gP[g])
    );
  end

  // Second-level lookahead across groups
  always_comb begin
    gC[0] = cin;
    for (int g = 0; g < NG; g++) begin
      logic c;
      logic pAll;
      c = 1'b0;
      for (int j = 0; j <= g; j++) begin
        logic term;
        term = gG[j];
        for (int m = j + 1; m <= g; m++) term = term & gP[m];
        c = c | term;
      end
      pAll = 1'b1;
      for (int m = 0; m <= g; m++) pAll = pAll & gP[m];
      gC[g+1] = c | (pAll & cin);
    end
  end

  assign cout = gC[NG];

endmodule

// File: rtl/alu16_datapath.sv
module alu16_datapath
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int GW    = 4,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic             invertA,
  input  logic             invertB,
  input  logic             signedMode,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             overflow,
  output logic             isZero
);

  logic [WIDTH-1:0] aEff, bEff, shOut, sumOut, lgOut;
  logic             carryOut, sOvf;

  assign aEff = invertA ? ~opA : opA;
  assign bEff = invertB ? ~opB : opB;

  alu16_shifter #(.WIDTH(WIDTH)) i_shift (
    .din (aEff),
    .amt (bEff[AMT_W-1:0]),
    .mode(strobes.shMode),
    .dout(shOut)
  );

  alu16_adder #(.WIDTH(WIDTH), .GW(GW)) i_add (
    .a   (aEff),
    .b   (bEff),
    .cin (carryIn),
    .sum (sumOut),
    .cout(carryOut)
  );

  always_comb begin
    unique case (strobes.lgOp)
      LG_OR:   lgOut = aEff | bEff;
      LG_XOR:  lgOut = aEff ^ bEff;
      LG_AND:  lgOut = aEff & bEff;
      default: lgOut = '0;
    endcase
  end

  always_comb begin
    unique case (strobes.resSel)
      RES_SHIFT: result = shOut;
      RES_SUM:   result = sumOut;
      RES_LOGIC: result = lgOut;
      default:   result = '0;
    endcase
  end

  // Same input signs, different sum sign
  assign sOvf     = (aEff[WIDTH-1] == bEff[WIDTH-1]) && (sumOut[WIDTH-1] != aEff[WIDTH-1]);
  assign overflow = strobes.ovfEn & (signedMode ? sOvf : carryOut);
  assign isZero   = (result == '0);

endmodule

// File: rtl/alu16_top.sv
module alu16_top
  import alu16_pkg::*;
(
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  input  logic        carryIn,
  input  logic [2:0]  opSel,
  input  logic        invertA,
  input  logic        invertB,
  input  logic        signedMode,
  output logic [15:0] result,
  output logic        overflow,
  output logic        isZero
);

  aluStrobes_t strobes;

  alu16_ctrl i_ctrl (
    .opSel  (opSel),
    .strobes(strobes)
  );

  alu16_datapath #(.WIDTH(16), .GW(4)) i_dp (
    .opA       (opA),
    .opB       (opB),
    .carryIn   (carryIn),
    .invertA   (invertA),
    .invertB   (invertB),
    .signedMode(signedMode),
    .strobes   (strobes),
    .result    (result),
    .overflow  (overflow),
    .isZero    (isZero)
  );

endmodule

// File: rtl/alu16_checks.sv
module alu16_checks (
  input logic [15:0] opA,
  input logic [15:0] opB,
  input logic        carryIn,
  input logic [2:0]  opSel,
  input logic        invertA,
  input logic        invertB,
  input logic        signedMode,
  input logic [15:0] result,
  input logic        overflow,
  input logic        isZero
);

  logic [15:0] aChk, bChk, lowMask;
  logic [16:0] wide;

  always_comb begin
    aChk    = invertA ? ~opA : opA;
    bChk    = invertB ? ~opB : opB;
    lowMask = ~(16'hFFFF << bChk[3:0]);
    wide    = {1'b0, aChk} + {1'b0, bChk} + {16'd0, carryIn};

    if (opSel == 3'b000)
      a_r1_rotate_keeps_ones: assert ($countones(result) == $countones(aChk))
        else $error("R1 rotate changed the number of ones");
    if (opSel == 3'b001)
      a_r2_shl_low_zero: assert ((result & lowMask) == 16'h0000)
        else $error("R2 vacated low bits not zero");
    if (opSel == 3'b010)
      a_r3_sar_sign_kept: assert (result[15] == aChk[15])
        else $error("R3 sign bit not kept");
    if (opSel == 3'b011 && bChk[3:0] != 4'd0)
      a_r4_shr_top_zero: assert (result[15] == 1'b0)
        else $error("R4 top bit not zero");
    if (opSel == 3'b100)
      a_r5_sum_low: assert (result == wide[15:0])
        else $error("R5 sum mismatch");
    if (opSel == 3'b111)
      a_r6_and_value: assert (result == (aChk & bChk))
        else $error("R6 AND mismatch");
    if (opSel == 3'b100 && !signedMode)
      a_r9_carry_flag: assert (overflow == wide[16])
        else $error("R9 unsigned overflow mismatch");
    if (opSel != 3'b100)
      a_r10_no_overflow: assert (!overflow)
        else $error("R10 overflow set outside add");
    if (opSel == 3'b110 && aChk == bChk)
      a_r11_xor_self_zero: assert (isZero && result == 16'h0000)
        else $error("R11 XOR of equal operands not zero");
  end

endmodule

bind alu16_top alu16_checks i_checks (
  .opA       (opA),
  .opB       (opB),
  .carryIn   (carryIn),
  .opSel     (opSel),
  .invertA   (invertA),
  .invertB   (invertB),
  .signedMode(signedMode),
  .result    (result),
  .overflow  (overflow),
  .isZero    (isZero)
);

// File: tb/test_alu16_top.sv
`timescale 1ns/1ps
module test_alu16_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic        carryIn = 1'b0, invertA = 1'b0, invertB = 1'b0, signedMode = 1'b0;
  logic [2:0]  opSel = 3'b000;
  logic [15:0] result;
  logic        overflow, isZero;

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alu16_top i_alu16_top (
    .opA(opA), .opB(opB), .carryIn(carryIn), .opSel(opSel),
    .invertA(invertA), .invertB(invertB), .signedMode(signedMode),
    .result(result), .overflow(overflow), .isZero(isZero)
  );

  localparam int NV = 12;
  logic [15:0] vecA [NV] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h8000, 16'h7FFF,
                             16'h1234, 16'hA5C3, 16'h0001, 16'h5555, 16'hFFFF, 16'h8001};
  logic [15:0] vecB [NV] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h0001, 16'h8000, 16'h7FFF,
                             16'h00F3, 16'h0005, 16'h000F, 16'hAAAA, 16'hFFFF, 16'h0008};

  // Reference in wider integer arithmetic: {overflow, zero, result}
  function automatic logic [17:0] refCalc(input logic [15:0] a, input logic [15:0] b,
                                          input logic [2:0] op, input logic ia,
                                          input logic ib, input logic ci, input logic sg);
    logic [15:0] x, y, r;
    logic [31:0] dbl;
    logic        o;
    int          n, u, s;
    x = ia ? ~a : a;
    y = ib ? ~b : b;
    n = int'(y[3:0]);
    o = 1'b0;
    case (op)
      3'b000: begin dbl = {x, x} << n; r = dbl[31:16]; end
      3'b001: r = x << n;
      3'b010: r = 16'($signed(x) >>> n);
      3'b011: r = x >> n;
      3'b100: begin
        u = int'(x) + int'(y) + int'(ci);
        s = int'($signed(x)) + int'($signed(y)) + int'(ci);
        r = u[15:0];
        o = sg ? (s > 32767 || s < -32768) : (u > 65535);
      end
      3'b101: r = x | y;
      3'b110: r = x ^ y;
      default: r = x & y;
    endcase
    return {o, (r == 16'h0000), r};
  endfunction

  function automatic string tagFor(input logic [2:0] op, input logic ia, input logic ib);
    string t;
    case (op)
      3'b000: t = "R1";
      3'b001: t = "R2";
      3'b010: t = "R3";
      3'b011: t = "R4";
      3'b100: t = "R5";
      default: t = "R6";
    endcase
    if (ia || ib) t = {t, "/R7"};
    return t;
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic applyAndCheck(input logic [15:0] a, input logic [15:0] b, input logic [2:0] op,
                               input logic ia, input logic ib, input logic ci, input logic sg);
    logic [17:0] e;
    string       ofTag;
    @(posedge clk);
    opA = a; opB = b; opSel = op; invertA = ia; invertB = ib; carryIn = ci; signedMode = sg;
    @(negedge clk);
    e = refCalc(a, b, op, ia, ib, ci, sg);
    ofTag = (op != 3'b100) ? "R10" : (sg ? "R8" : "R9");
    cmp($sformatf("%s op=%b a=%h b=%h ia=%b ib=%b ci=%b", tagFor(op, ia, ib), op, a, b, ia, ib, ci),
        32'(result), 32'(e[15:0]));
    cmp($sformatf("%s overflow op=%b a=%h b=%h ci=%b", ofTag, op, a, b, ci), 32'(overflow), 32'(e[17]));
    cmp($sformatf("R11 zero op=%b a=%h b=%h", op, a, b), 32'(isZero), 32'(e[16]));
  endtask

  task automatic sweepOp(input logic [2:0] op);
    for (int v = 0; v < NV; v++)
      for (int m = 0; m < 16; m++)
        applyAndCheck(vecA[v], vecB[v], op, m[0], m[1], m[2], m[3]);
  endtask

  task automatic testReset;
    @(negedge clk);
    cmp("R1 reset-state result", 32'(result), 32'h0);
    cmp("R11 reset-state zero", 32'(isZero), 32'h1);
    cmp("R10 reset-state overflow", 32'(overflow), 32'h0);
  endtask

  task automatic testRotate;
    sweepOp(3'b000);
    for (int n = 0; n < 16; n++) applyAndCheck(16'h8001, 16'(n), 3'b000, 0, 0, 0, 0);
  endtask

  task automatic testShifts;
    sweepOp(3'b001);
    sweepOp(3'b010);
    sweepOp(3'b011);
    for (int n = 0; n < 16; n++) begin
      applyAndCheck(16'hC3A5, 16'(n), 3'b010, 0, 0, 0, 0);
      applyAndCheck(16'hC3A5, 16'(n), 3'b011, 0, 0, 0, 0);
    end
  endtask

  task automatic testAddSub;
    sweepOp(3'b100);
    // R5 subtraction: A - B via invertB with carryIn
    applyAndCheck(16'h0005, 16'h0007, 3'b100, 0, 1, 1, 1);
    cmp("R5 subtract 5-7", 32'(result), 32'h0000FFFE);
    applyAndCheck(16'h8000, 16'h0001, 3'b100, 0, 1, 1, 1);
    cmp("R8 signed overflow on min-1", 32'(overflow), 32'h1);
    applyAndCheck(16'hFFFF, 16'h0001, 3'b100, 0, 0, 0, 0);
    cmp("R9 carry and R11 zero together", 32'({overflow, isZero}), 32'h3);
  endtask

  task automatic testLogic;
    sweepOp(3'b101);
    sweepOp(3'b110);
    sweepOp(3'b111);
  endtask

  task automatic testCarryIgnored;
    logic [15:0] r0;
    logic [1:0]  f0;
    for (int op = 0; op < 8; op++) begin
      if (op == 4) continue;
      applyAndCheck(16'h9C31, 16'h0F06, 3'(op), 0, 0, 0, 1);
      r0 = result; f0 = {overflow, isZero};
      applyAndCheck(16'h9C31, 16'h0F06, 3'(op), 0, 0, 1, 1);
      cmp($sformatf("R12 carryIn no effect op=%0d", op), 32'({overflow, isZero, result}),
          32'({f0, r0}));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    testReset();
    testRotate();
    testShifts();
    testAddSub();
    testLogic();
    testCarryIgnored();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule